// File: doc/BRIEF.md
# Exception Sequencing Unit

This unit is the event and return sequencing logic of a small 32-bit processor core. The core feeds it two internal fault strobes: an undefined opcode and an arithmetic overflow. It also feeds the address of the instruction now at the fault-detection point. When a fault is raised and the global enable is set, the unit takes the event. It writes a 5-bit reason code into its cause register and keeps the faulting instruction's address in a dedicated saved-address register, much as a link register holds a return address. It clears the global enable so that the handler is not entered again. In the next cycle it tells the fetch stage to discard younger work and to restart at the fixed handler address 0x8000_0180.

A return strobe from the handler sends fetch back to the saved address and sets the enable again in the same step. The handler may also set the enable itself through a single-bit write port. This lets a later fault interrupt the handler, and that fault then overwrites the cause and the saved address. When the enable is clear, fault strobes have no effect at all.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the enable is 0, the cause register is 0, the saved address is 0, and both the redirect-valid and flush outputs are 0.
- R2: An undefined-opcode strobe sampled while the enable is 1 writes cause code 0x0A at that clock edge.
- R3: An overflow strobe sampled alone while the enable is 1 writes cause code 0x0C at that clock edge.
- R4: When both fault strobes are sampled together with the enable set, the undefined opcode wins and the cause becomes 0x0A.
- R5: A taken fault stores the current PC input itself, not PC+4, into the saved-address register.
- R6: In the cycle after a fault is taken, flush and redirect-valid are both 1 and the redirect address is 0x8000_0180. Flush is high for exactly one cycle.
- R7: Taking a fault clears the enable at the same edge.
- R8: A fault strobe sampled while the enable is 0 changes neither the cause nor the saved address. It raises neither flush nor redirect-valid.
- R9: A return strobe that is not overridden by a taken fault sets the enable. In the following cycle redirect-valid is 1 with the redirect address equal to the saved address, and flush stays 0.
- R10: A write on the enable port loads the written bit into the enable unless a fault is taken or a return is accepted in the same cycle. A taken fault leaves the enable at 0; an accepted return leaves it at 1.
- R11: If a fault is taken in the same cycle as a return strobe, the fault is handled and the return is dropped.
- R12: Once the handler sets the enable again, a second fault overwrites the cause and the saved address (nested entry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| undefOp | input | 1 | Undefined-opcode fault strobe |
| arithOvf | input | 1 | Arithmetic-overflow fault strobe |
| curPc | input | 32 | Address of the instruction at the fault point |
| retStrobe | input | 1 | Return-from-handler strobe |
| ieWrEn | input | 1 | Enable write strobe |
| ieWrData | input | 1 | Value written to the enable |
| intEnable | output | 1 | Current global enable |
| causeOut | output | 5 | Cause register |
| epcOut | output | 32 | Saved return address |
| redirectValid | output | 1 | Fetch redirect request |
| pcRedirect | output | 32 | Fetch redirect target |
| flushOut | output | 1 | Discard-younger-work pulse |

## Verification
Every result is registered once, so every result shows up at the first rising edge that samples its stimulus. That covers the cause, the saved address, the enable, the redirect pair and the flush pulse. The bench drives inputs on the falling edge and reads outputs one time unit after the next rising edge. It then runs one idle cycle and reads again, which confirms that flush and redirect-valid fall after exactly one cycle. A bench model carries the cause, the saved address and the enable across all sixteen combinations of enable, both fault strobes and the return strobe, at several PC values, so the result held from the previous step is checked every time.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic takeEvt;   // fault accepted this cycle
    logic selUndef;  // undefined opcode chosen as reason
    logic doRet;     // return accepted this cycle
  } excStrobes_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        undefOp,
  input  logic        arithOvf,
  input  logic        retStrobe,
  input  logic        ieWrEn,
  input  logic        ieWrData,
  output excStrobes_t strobes,
  output logic        intEnable,
  output logic        flushOut
);
  logic anyFault;

  always_comb begin
    anyFault         = undefOp || arithOvf;
    strobes.takeEvt  = intEnable && anyFault;
    strobes.selUndef = undefOp;
    strobes.doRet    = retStrobe && !(intEnable && anyFault);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEnable <= 1'b0;
      flushOut  <= 1'b0;
    end else begin
      flushOut <= strobes.takeEvt;
      if (strobes.takeEvt)     intEnable <= 1'b0;
      else if (strobes.doRet)  intEnable <= 1'b1;
      else if (ieWrEn)         intEnable <= ieWrData;
    end
  end

  AST_TAKE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable && (undefOp || arithOvf)) |=> !intEnable); // R7
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut); // R6
  AST_OFF_NO_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> !flushOut); // R8
  AST_RET_SETS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !undefOp && !arithOvf) |=> intEnable); // R9
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          CAUSE_W     = 5,
  parameter logic [XLEN-1:0]    VECTOR_ADDR = 32'h8000_0180,
  parameter logic [CAUSE_W-1:0] CODE_UNDEF  = 5'h0A,
  parameter logic [CAUSE_W-1:0] CODE_OVF    = 5'h0C
) (
  input  logic               clk,
  input  logic               rstN,
  input  excStrobes_t        strobes,
  input  logic [XLEN-1:0]    curPc,
  output logic [CAUSE_W-1:0] causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic               redirectValid,
  output logic [XLEN-1:0]    pcRedirect
);
  logic [CAUSE_W-1:0] nextCause;

  always_comb nextCause = strobes.selUndef ? CODE_UNDEF : CODE_OVF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeOut      <= '0;
      epcOut        <= '0;
      redirectValid <= 1'b0;
      pcRedirect    <= '0;
    end else begin
      redirectValid <= strobes.takeEvt || strobes.doRet;
      if (strobes.takeEvt) begin
        causeOut   <= nextCause;
        epcOut     <= curPc;
        pcRedirect <= VECTOR_ADDR;
      end else if (strobes.doRet) begin
        pcRedirect <= epcOut;
      end
    end
  end

  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeEvt |=> (redirectValid && pcRedirect == VECTOR_ADDR)); // R6
  AST_EPC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeEvt |=> $stable(epcOut)); // R8
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.takeEvt |=> $stable(causeOut)); // R8
  AST_EPC_IS_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeEvt |=> epcOut == $past(curPc)); // R5
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               undefOp,
  input  logic               arithOvf,
  input  logic [XLEN-1:0]    curPc,
  input  logic               retStrobe,
  input  logic               ieWrEn,
  input  logic               ieWrData,
  output logic               intEnable,
  output logic [CAUSE_W-1:0] causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic               redirectValid,
  output logic [XLEN-1:0]    pcRedirect,
  output logic               flushOut
);
  excStrobes_t strobes;

  exc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .undefOp(undefOp), .arithOvf(arithOvf),
    .retStrobe(retStrobe), .ieWrEn(ieWrEn), .ieWrData(ieWrData),
    .strobes(strobes), .intEnable(intEnable), .flushOut(flushOut)
  );

  exc_datapath #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPc(curPc),
    .causeOut(causeOut), .epcOut(epcOut),
    .redirectValid(redirectValid), .pcRedirect(pcRedirect)
  );

  AST_UNDEF_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable && undefOp) |=> causeOut == 5'h0A); // R4
endmodule

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0, rstN = 1'b0;
  logic undefOp = 0, arithOvf = 0, retStrobe = 0, ieWrEn = 0, ieWrData = 0;
  logic [31:0] curPc = '0;
  logic intEnable, redirectValid, flushOut;
  logic [4:0] causeOut;
  logic [31:0] epcOut, pcRedirect;

  int nChecks = 0, nFails = 0;
  logic mEn;
  logic [4:0] mCause;
  logic [31:0] mEpc;

  exc_ctrl_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at falling edge, sample 1 unit after the rising edge
  task automatic step;
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic setEn(input logic v);
    @(negedge clk);
    ieWrEn = 1; ieWrData = v;
    @(posedge clk); #1;
    @(negedge clk);
    ieWrEn = 0;
    mEn = v;
    chk(intEnable == v, "R10 enable write", {31'b0, intEnable}, {31'b0, v});
  endtask

  task automatic apply(input logic u, input logic o, input logic r, input logic [31:0] pc);
    logic take, retOk;
    logic [31:0] oldEpc;
    string tag;
    take = mEn && (u || o);
    retOk = r && !take;
    oldEpc = mEpc;
    if (take && u && o) tag = "R4";
    else if (take && r) tag = "R11";
    else if (take && u) tag = "R2";
    else if (take) tag = "R3";
    else if (u || o) tag = "R8";
    else if (r) tag = "R9";
    else tag = "R10";
    @(negedge clk);
    undefOp = u; arithOvf = o; retStrobe = r; curPc = pc;
    @(posedge clk); #1;
    if (take) begin
      mCause = u ? 5'h0A : 5'h0C;
      mEpc = pc;
      mEn = 1'b0;
    end else if (retOk) mEn = 1'b1;
    chk(causeOut == mCause, {tag, " cause"}, {27'b0, causeOut}, {27'b0, mCause});
    chk(epcOut == mEpc, {take ? "R5" : tag, " saved address"}, epcOut, mEpc);
    chk(intEnable == mEn, {take ? "R7" : tag, " enable"}, {31'b0, intEnable}, {31'b0, mEn});
    chk(flushOut == take, {take ? "R6" : tag, " flush"}, {31'b0, flushOut}, {31'b0, take});
    chk(redirectValid == (take || retOk), {tag, " redirect valid"}, {31'b0, redirectValid}, {31'b0, take || retOk});
    if (take) chk(pcRedirect == VEC, "R6 vector", pcRedirect, VEC);
    else if (retOk) chk(pcRedirect == oldEpc, "R9 return target", pcRedirect, oldEpc);
    @(negedge clk);
    undefOp = 0; arithOvf = 0; retStrobe = 0;
    @(posedge clk); #1;
    chk(flushOut == 0, "R6 flush one cycle", {31'b0, flushOut}, 32'd0);
    chk(redirectValid == 0, "R6 redirect one cycle", {31'b0, redirectValid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    mEn = 0; mCause = 0; mEpc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk(intEnable == 0, "R1 enable", {31'b0, intEnable}, 32'd0);
    chk(causeOut == 0, "R1 cause", {27'b0, causeOut}, 32'd0);
    chk(epcOut == 0, "R1 saved address", epcOut, 32'd0);
    chk(redirectValid == 0 && flushOut == 0, "R1 redirect/flush", {30'b0, redirectValid, flushOut}, 32'd0);

    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) begin
        setEn(c[3]);
        apply(c[2], c[1], c[0], 32'h0040_0000 + 32'(p * 256 + c * 4));
      end
    end

    // R12: nested entry after handler re-enables
    setEn(1);
    apply(1, 0, 0, 32'h0000_2000);
    setEn(1);
    apply(0, 1, 0, 32'h0000_3004);
    chk(causeOut == 5'h0C && epcOut == 32'h0000_3004, "R12 nested overwrite",
        epcOut, 32'h0000_3004);

    // R10: write loses to a taken fault in the same cycle
    setEn(1);
    @(negedge clk);
    undefOp = 1; ieWrEn = 1; ieWrData = 1; curPc = 32'h0000_4000;
    @(posedge clk); #1;
    chk(intEnable == 0, "R10 write vs fault", {31'b0, intEnable}, 32'd0);
    @(negedge clk);
    undefOp = 0; ieWrEn = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule